// File: doc/BRIEF.md
# Descriptor Fetch and Completion Controller

This block runs one channel of a scatter-gather copy engine. Host software puts a table in host memory. The table begins with a status header of one dword per descriptor. The descriptor slots follow the header. Software tells the controller where the table lives and where the local descriptor queue sits, then writes the ID of the final descriptor. That single write starts the run. No separate go bit exists.

While it runs, the controller reads descriptors one at a time over a read master. It starts at ID 0 and climbs to the programmed final ID. It hands each descriptor to the local data mover through a command port, which also supplies the queue slot address for that descriptor. It then waits until the mover reports that the final descriptor's transfer is complete. At that point it writes a 1 into that descriptor's header dword in host memory, and software polls that dword. A read and a write channel are each built from one instance of this block, with different queue base values (0x80000000 and 0x80002000). Both may run at once.

Top module: `desc_fetch_ctrl`

## Requirements
- R1: After reset the controller is idle: the status register (word index 4) reads 0, and rd_req, cmd_valid and wr_req are all low.
- R2: A register write of the final ID (word index 3) while idle starts a run, and the busy bit (status bit 0) reads 1 on the next cycle.
- R3: Descriptor reads go out in ascending order, one per ID from 0 to the final ID, at address table_base + 0x200 + 32*N. The table base is formed from word index 0 (low half) and word index 1 (high half).
- R4: No descriptor read is issued in any cycle in which cmd_full is high.
- R5: At most one descriptor read is outstanding. After rd_req is accepted, no new request is made until rd_rvalid returns.
- R6: Each returned descriptor is forwarded on cmd_valid in the same cycle as rd_rvalid. The source comes from response bits [63:0], the destination from bits [127:64], the size in dwords from bits [159:128] and the ID from bits [166:160]. The slot address is queue_base + 32*N, where the queue base is word index 2.
- R7: The completion write goes to table_base + 4*final_ID with data 1. wr_req and wr_addr are held until wr_ack, and the write happens only after every descriptor has been forwarded.
- R8: A write to the final-ID register while busy is ignored. The register keeps its value, and the run fetches the originally programmed count.
- R9: The busy bit stays 1 until the completion write is acknowledged, and reads 0 after that.
- R10: The completion write is not issued until mv_done reports the final ID. Completions for other IDs do not trigger it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| rd_req | output | 1 | Descriptor read request, accepted on the clock edge |
| rd_addr | output | 64 | Host address of the descriptor being fetched |
| rd_rvalid | input | 1 | Descriptor read response valid |
| rd_rdata | input | 256 | Descriptor read response data |
| cmd_valid | output | 1 | Descriptor handed to the data mover |
| cmd_addr | output | 32 | Local queue slot address |
| cmd_src | output | 64 | Transfer source address |
| cmd_dst | output | 64 | Transfer destination address |
| cmd_size | output | 32 | Transfer size in dwords |
| cmd_id | output | 7 | Descriptor ID |
| cmd_full | input | 1 | Local descriptor queue is full |
| mv_done | input | 1 | Data mover finished one descriptor |
| mv_done_id | input | 7 | ID of the finished descriptor |
| wr_req | output | 1 | Completion flag write request |
| wr_addr | output | 64 | Host address of the header dword |
| wr_data | output | 32 | Completion flag data |
| wr_ack | input | 1 | Completion write accepted |

## Verification
The controller is run with the final ID set to 0, 3, 5 and 127, with different table bases and queue bases, and with descriptor contents that change per run. These cases separate correct slot arithmetic and ID order from off-by-one or stale-register faults. In one run the queue-full input is held at the start, which shows whether fetching is actually gated. In another run the final-ID register is rewritten mid-run, which shows whether that write is blocked while busy. A slow mover that completes earlier IDs long before the final one shows whether the flag write waits for the right ID and not for just any completion.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
    localparam int ID_W       = 7;
    localparam int AW         = 64;
    localparam int LW         = 32;
    localparam int DW         = 32;
    localparam int SIZE_W     = 32;
    localparam int RA_W       = 3;
    localparam int DESC_BYTES = 32;
    localparam int DESC_BITS  = DESC_BYTES * 8;
    localparam int DESC_SH    = $clog2(DESC_BYTES);
    localparam int FLAG_SH    = $clog2(DW / 8);
    localparam int HDR_BYTES  = (2 ** ID_W) * (DW / 8);

    // bit positions of fields inside one fetched descriptor
    localparam int SRC_LSB  = 0;
    localparam int DST_LSB  = SRC_LSB + AW;
    localparam int SIZE_LSB = DST_LSB + AW;
    localparam int ID_LSB   = SIZE_LSB + SIZE_W;

    // register word indices
    localparam logic [RA_W-1:0] RA_TBL_LO = RA_W'(0);
    localparam logic [RA_W-1:0] RA_TBL_HI = RA_W'(1);
    localparam logic [RA_W-1:0] RA_QBASE  = RA_W'(2);
    localparam logic [RA_W-1:0] RA_LAST   = RA_W'(3);
    localparam logic [RA_W-1:0] RA_STAT   = RA_W'(4);

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_WAIT,
        S_DRAIN,
        S_FLAG
    } state_t;

    typedef struct packed {
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [SIZE_W-1:0] size;
        logic [ID_W-1:0]   id;
    } desc_t;

    function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                                input logic [ID_W-1:0] id);
        return base + AW'(HDR_BYTES) + (AW'(id) << DESC_SH);
    endfunction

    function automatic logic [AW-1:0] flag_addr(input logic [AW-1:0] base,
                                                input logic [ID_W-1:0] id);
        return base + (AW'(id) << FLAG_SH);
    endfunction
endpackage

// File: rtl/dfc_unpack.sv
module dfc_unpack
    import dfc_pkg::*;
(
    input  logic [DESC_BITS-1:0] raw,
    output desc_t                desc
);
    logic unused_pad;

    assign desc.src   = raw[SRC_LSB  +: AW];
    assign desc.dst   = raw[DST_LSB  +: AW];
    assign desc.size  = raw[SIZE_LSB +: SIZE_W];
    assign desc.id    = raw[ID_LSB   +: ID_W];
    assign unused_pad = ^raw[DESC_BITS-1:ID_LSB+ID_W];
endmodule

// File: rtl/dfc_regs.sv
module dfc_regs
    import dfc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            busy,
    output logic [DW-1:0]   reg_rdata,
    output logic [AW-1:0]   tbl_base,
    output logic [LW-1:0]   q_base,
    output logic [ID_W-1:0] last_id,
    output logic            start
);
    logic [DW-1:0]   tbl_lo_q, tbl_hi_q;
    logic [LW-1:0]   q_base_q;
    logic [ID_W-1:0] last_q;

    assign start = reg_we && (reg_addr == RA_LAST) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_lo_q <= '0;
            tbl_hi_q <= '0;
            q_base_q <= '0;
            last_q   <= '0;
        end else begin
            if (reg_we && reg_addr == RA_TBL_LO) tbl_lo_q <= reg_wdata;
            if (reg_we && reg_addr == RA_TBL_HI) tbl_hi_q <= reg_wdata;
            if (reg_we && reg_addr == RA_QBASE)  q_base_q <= LW'(reg_wdata);
            if (start)                           last_q   <= reg_wdata[ID_W-1:0];
        end
    end

    always_comb begin
        case (reg_addr)
            RA_TBL_LO: reg_rdata = tbl_lo_q;
            RA_TBL_HI: reg_rdata = tbl_hi_q;
            RA_QBASE:  reg_rdata = DW'(q_base_q);
            RA_LAST:   reg_rdata = DW'(last_q);
            RA_STAT:   reg_rdata = DW'(busy);
            default:   reg_rdata = '0;
        endcase
    end

    assign tbl_base = {tbl_hi_q, tbl_lo_q};
    assign q_base   = q_base_q;
    assign last_id  = last_q;

    // R2: a start is followed by the busy state
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R8: a final-ID write during a run leaves the register alone
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == RA_LAST && busy) |=> $stable(last_q));
endmodule

// File: rtl/dfc_seq.sv
module dfc_seq
    import dfc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [ID_W-1:0] last_id,
    input  logic [AW-1:0]   tbl_base,
    input  logic [LW-1:0]   q_base,
    input  logic            cmd_full,
    input  logic            rd_rvalid,
    input  logic            mv_done,
    input  logic [ID_W-1:0] mv_done_id,
    input  logic            wr_ack,
    output logic            busy,
    output logic            rd_req,
    output logic [AW-1:0]   rd_addr,
    output logic            cmd_valid,
    output logic [LW-1:0]   cmd_addr,
    output logic            wr_req,
    output logic [AW-1:0]   wr_addr,
    output logic [DW-1:0]   wr_data
);
    state_t          state_q, state_d;
    logic [ID_W-1:0] idx_q;
    logic            seen_q;
    logic            last_hit;

    assign last_hit = mv_done && (mv_done_id == last_id);

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:  if (start) state_d = S_FETCH;
            S_FETCH: if (!cmd_full) state_d = S_WAIT;
            S_WAIT:  if (rd_rvalid) state_d = (idx_q == last_id) ? S_DRAIN : S_FETCH;
            S_DRAIN: if (seen_q || last_hit) state_d = S_FLAG;
            S_FLAG:  if (wr_ack) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            seen_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                idx_q  <= '0;
                seen_q <= 1'b0;
            end else begin
                if (state_q == S_WAIT && rd_rvalid && idx_q != last_id)
                    idx_q <= idx_q + 1'b1;
                if (state_q != S_IDLE && last_hit)
                    seen_q <= 1'b1;
            end
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign rd_req    = (state_q == S_FETCH) && !cmd_full;
    assign rd_addr   = slot_addr(tbl_base, idx_q);
    assign cmd_valid = (state_q == S_WAIT) && rd_rvalid;
    assign cmd_addr  = q_base + (LW'(idx_q) << DESC_SH);
    assign wr_req    = (state_q == S_FLAG);
    assign wr_addr   = flag_addr(tbl_base, last_id);
    assign wr_data   = DW'(1);

    // R4: a full queue keeps the fetcher parked
    p_park_full_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FETCH && cmd_full) |=> state_q == S_FETCH);

    // R5: an accepted request is never followed directly by another
    p_one_out_r5: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R7: the flag write is held steady until acknowledged
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr)));

    // R10: the flag write only starts once the final ID has completed
    p_flag_after_done_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_req) |-> seen_q);
endmodule

// File: rtl/desc_fetch_ctrl.sv
module desc_fetch_ctrl
    import dfc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [RA_W-1:0]      reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 rd_req,
    output logic [AW-1:0]        rd_addr,
    input  logic                 rd_rvalid,
    input  logic [DESC_BITS-1:0] rd_rdata,
    output logic                 cmd_valid,
    output logic [LW-1:0]        cmd_addr,
    output logic [AW-1:0]        cmd_src,
    output logic [AW-1:0]        cmd_dst,
    output logic [SIZE_W-1:0]    cmd_size,
    output logic [ID_W-1:0]      cmd_id,
    input  logic                 cmd_full,
    input  logic                 mv_done,
    input  logic [ID_W-1:0]      mv_done_id,
    output logic                 wr_req,
    output logic [AW-1:0]        wr_addr,
    output logic [DW-1:0]        wr_data,
    input  logic                 wr_ack
);
    logic            busy, start;
    logic [AW-1:0]   tbl_base;
    logic [LW-1:0]   q_base;
    logic [ID_W-1:0] last_id;
    desc_t           rsp;

    dfc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .reg_rdata (reg_rdata),
        .tbl_base  (tbl_base),
        .q_base    (q_base),
        .last_id   (last_id),
        .start     (start)
    );

    dfc_unpack u_unpack (
        .raw  (rd_rdata),
        .desc (rsp)
    );

    dfc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .last_id    (last_id),
        .tbl_base   (tbl_base),
        .q_base     (q_base),
        .cmd_full   (cmd_full),
        .rd_rvalid  (rd_rvalid),
        .mv_done    (mv_done),
        .mv_done_id (mv_done_id),
        .wr_ack     (wr_ack),
        .busy       (busy),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .cmd_valid  (cmd_valid),
        .cmd_addr   (cmd_addr),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    assign cmd_src  = rsp.src;
    assign cmd_dst  = rsp.dst;
    assign cmd_size = rsp.size;
    assign cmd_id   = rsp.id;
endmodule

// File: tb/desc_fetch_ctrl_tb_top.sv
module desc_fetch_ctrl_tb_top;
    import dfc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic                 reg_we = 1'b0;
    logic [RA_W-1:0]      reg_addr = '0;
    logic [DW-1:0]        reg_wdata = '0;
    logic [DW-1:0]        reg_rdata;
    logic                 rd_req;
    logic [AW-1:0]        rd_addr;
    logic                 rd_rvalid = 1'b0;
    logic [DESC_BITS-1:0] rd_rdata = '0;
    logic                 cmd_valid;
    logic [LW-1:0]        cmd_addr;
    logic [AW-1:0]        cmd_src, cmd_dst;
    logic [SIZE_W-1:0]    cmd_size;
    logic [ID_W-1:0]      cmd_id;
    logic                 cmd_full = 1'b0;
    logic                 mv_done = 1'b0;
    logic [ID_W-1:0]      mv_done_id = '0;
    logic                 wr_req;
    logic [AW-1:0]        wr_addr;
    logic [DW-1:0]        wr_data;
    logic                 wr_ack = 1'b0;

    desc_fetch_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_src(cmd_src),
        .cmd_dst(cmd_dst), .cmd_size(cmd_size), .cmd_id(cmd_id),
        .cmd_full(cmd_full), .mv_done(mv_done), .mv_done_id(mv_done_id),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
    );

    typedef struct packed {
        logic [LW-1:0]     addr;
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [SIZE_W-1:0] size;
        logic [ID_W-1:0]   id;
    } exp_t;

    int checks = 0;
    int fails  = 0;

    exp_t            sb_q[$];
    logic [AW-1:0]   exp_rd_q[$];
    logic [ID_W-1:0] mv_q[$];

    int              salt = 0;
    int              mv_gap = 3;
    int              rd_lat_cfg = 1;
    logic [AW-1:0]   cur_tbl = '0;
    logic [ID_W-1:0] cur_last = '0;
    bit              last_done_sent = 1'b0;
    int              rd_seen = 0;
    int              wr_count = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] f_src(input logic [ID_W-1:0] id, input int s);
        return 64'hA500_0000_0000_0000 | (AW'(s) << 32) | (AW'(id) << 4);
    endfunction

    function automatic logic [SIZE_W-1:0] f_size(input logic [ID_W-1:0] id, input int s);
        return SIZE_W'(id) * 3 + SIZE_W'(s) + 1;
    endfunction

    function automatic logic [DESC_BITS-1:0] mk_raw(input logic [ID_W-1:0] id, input int s);
        logic [DESC_BITS-1:0] r;
        r = '1;
        r[63:0]    = f_src(id, s);
        r[127:64]  = ~f_src(id, s);
        r[159:128] = f_size(id, s);
        r[166:160] = id;
        return r;
    endfunction

    // host memory, data mover and flag-write target models plus monitor
    always begin : models
        bit              rd_pend;
        int              rd_lat;
        logic [AW-1:0]   rd_pend_addr;
        int              mv_timer;
        bit              wr_open;
        int              wr_wait;
        bit              acked_now;
        logic [AW-1:0]   e;
        exp_t            x;
        @(negedge clk);
        rd_rvalid = 1'b0;
        mv_done   = 1'b0;
        wr_ack    = 1'b0;
        acked_now = 1'b0;
        if (rd_pend) begin
            if (rd_lat == 0) begin
                rd_rvalid = 1'b1;
                rd_rdata  = mk_raw(ID_W'((rd_pend_addr - cur_tbl - AW'(HDR_BYTES)) >> DESC_SH), salt);
                rd_pend   = 1'b0;
            end else rd_lat--;
        end
        if (mv_q.size() > 0) begin
            if (mv_timer <= 0) begin
                mv_done    = 1'b1;
                mv_done_id = mv_q.pop_front();
                if (mv_done_id == cur_last) last_done_sent = 1'b1;
                mv_timer   = mv_gap;
            end else mv_timer--;
        end
        if (wr_open) begin
            if (wr_wait == 0) begin
                wr_ack    = 1'b1;
                wr_open   = 1'b0;
                acked_now = 1'b1;
            end else wr_wait--;
        end
        #1;
        if (!rst) begin
            if (rd_req) begin
                rd_seen++;
                chk(!rd_pend, "R5 one outstanding read", AW'(rd_pend), '0);
                chk(!cmd_full, "R4 no fetch while full", AW'(cmd_full), '0);
                if (exp_rd_q.size() == 0) chk(1'b0, "R3 unexpected read", rd_addr, '0);
                else begin
                    e = exp_rd_q.pop_front();
                    chk(rd_addr == e, "R3 fetch address order", rd_addr, e);
                end
                rd_pend      = 1'b1;
                rd_lat       = rd_lat_cfg;
                rd_pend_addr = rd_addr;
            end
            if (cmd_valid) begin
                if (sb_q.size() == 0) chk(1'b0, "R6 unexpected command", AW'(cmd_id), '0);
                else begin
                    x = sb_q.pop_front();
                    chk(cmd_addr == x.addr, "R6 queue slot address", AW'(cmd_addr), AW'(x.addr));
                    chk(cmd_src == x.src, "R6 source field", cmd_src, x.src);
                    chk(cmd_dst == x.dst, "R6 destination field", cmd_dst, x.dst);
                    chk(cmd_size == x.size, "R6 size field", AW'(cmd_size), AW'(x.size));
                    chk(cmd_id == x.id, "R3 ascending id", AW'(cmd_id), AW'(x.id));
                end
                mv_q.push_back(cmd_id);
            end
            if (wr_open && !wr_req)
                chk(1'b0, "R7 flag request dropped before ack", '0, 64'd1);
            if (wr_req && !acked_now && !wr_open) begin
                wr_count++;
                chk(last_done_sent, "R10 flag only after final id done", AW'(last_done_sent), 64'd1);
                chk(wr_addr == cur_tbl + (AW'(cur_last) << 2), "R7 flag address",
                    wr_addr, cur_tbl + (AW'(cur_last) << 2));
                chk(wr_data == 32'd1, "R7 flag data", AW'(wr_data), 64'd1);
                chk(sb_q.size() == 0, "R7 all forwarded before flag", AW'(sb_q.size()), '0);
                wr_open = 1'b1;
                wr_wait = 2;
            end
        end
    end

    task automatic reg_write(input logic [RA_W-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we   = 1'b0;
        reg_addr = RA_STAT;
    endtask

    // driver: pushes the expected fetch and command stream, then starts
    task automatic start_run(input logic [AW-1:0] tbl, input logic [LW-1:0] qb,
                             input logic [ID_W-1:0] last);
        exp_t it;
        salt++;
        cur_tbl        = tbl;
        cur_last       = last;
        last_done_sent = 1'b0;
        for (int n = 0; n <= int'(last); n++) begin
            exp_rd_q.push_back(tbl + 64'h200 + 64'(32 * n));
            it.addr = qb + LW'(32 * n);
            it.src  = f_src(ID_W'(n), salt);
            it.dst  = ~f_src(ID_W'(n), salt);
            it.size = f_size(ID_W'(n), salt);
            it.id   = ID_W'(n);
            sb_q.push_back(it);
        end
        reg_write(RA_TBL_LO, tbl[31:0]);
        reg_write(RA_TBL_HI, tbl[63:32]);
        reg_write(RA_QBASE, qb);
        reg_write(RA_LAST, DW'(last));
        #1;
        chk(reg_rdata[0] == 1'b1, "R2 busy right after final-id write", AW'(reg_rdata), 64'd1);
    endtask

    task automatic finish_run(input int wr_before);
        bit idle;
        idle = 1'b0;
        for (int c = 0; c < 6000 && !idle; c++) begin
            @(negedge clk);
            reg_addr = RA_STAT;
            #1;
            if (reg_rdata[0] == 1'b0) idle = 1'b1;
        end
        chk(idle, "R9 busy clears after run", AW'(idle), 64'd1);
        chk(wr_count == wr_before + 1, "R9 busy held until flag write acked",
            AW'(wr_count), AW'(wr_before + 1));
        chk(exp_rd_q.size() == 0, "R3 every descriptor fetched", AW'(exp_rd_q.size()), '0);
        chk(sb_q.size() == 0, "R6 every descriptor forwarded", AW'(sb_q.size()), '0);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired before the run list completed");
        summary();
        $finish;
    end

    initial begin : scenario
        int w;
        int r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        reg_addr = RA_STAT;
        #1;
        chk(reg_rdata == '0, "R1 status idle after reset", AW'(reg_rdata), '0);
        chk(!rd_req && !cmd_valid && !wr_req, "R1 request outputs low after reset",
            AW'({rd_req, cmd_valid, wr_req}), '0);

        // plain run of four descriptors
        w = wr_count;
        start_run(64'h0000_0001_2000_0000, 32'h8000_0000, 7'd3);
        finish_run(w);

        // queue full at start: no fetch until released
        w = wr_count;
        cmd_full = 1'b1;
        r0 = rd_seen;
        start_run(64'h0000_0000_4000_0400, 32'h8000_2000, 7'd2);
        repeat (10) @(negedge clk);
        chk(rd_seen == r0, "R4 no read while queue full", AW'(rd_seen), AW'(r0));
        cmd_full = 1'b0;
        finish_run(w);

        // rewrite of final id during a run is ignored
        w = wr_count;
        rd_lat_cfg = 2;
        start_run(64'h0000_0002_0000_0000, 32'h8000_0000, 7'd5);
        repeat (2) @(negedge clk);
        reg_write(RA_LAST, 32'd1);
        reg_addr = RA_LAST;
        #1;
        chk(reg_rdata == 32'd5, "R8 final id unchanged while busy", AW'(reg_rdata), 64'd5);
        finish_run(w);

        // single descriptor
        w = wr_count;
        rd_lat_cfg = 0;
        start_run(64'h0000_0000_0001_0000, 32'h8000_0000, 7'd0);
        finish_run(w);

        // full table with high table base
        w = wr_count;
        start_run(64'hFFFF_0000_0000_1000, 32'h8000_2000, 7'd127);
        finish_run(w);

        // slow mover: earlier completions must not trigger the flag
        w = wr_count;
        mv_gap = 25;
        start_run(64'h0000_0003_0000_8000, 32'h8000_0000, 7'd3);
        finish_run(w);

        summary();
        $finish;
    end
endmodule